// File: doc/BRIEF.md
# Open-Drain Line Repeater

This block joins two open-drain data lines, one on the host side and one on the card side, so that a low driven by either party appears on the other. Each side is seen through a sampled input and is driven by two enables: a pull-down and a short active pull-up pulse. An external resistor holds each line high when nobody drives. The block works out which side started a low pulse, copies that low to the other side after a fixed delay, and, once the leading side lets go, releases the copy and kicks the line high with an active pull-up pulse of the same length.

The side that falls first is the master for that transfer. Edges on the other side are ignored until the transfer has fully ended. An enable input marks whether the card interface is powered. While it is low, the card line is held to ground and the host line is left released. One instance serves each line, so a card slot uses three of them: the data line and two auxiliary lines.

The copy delay is a parameter. By default it is worked out from the system clock frequency so that it spans about 200 ns.

Top module: `odl_repeater`

## Requirements
- R1: With the link enabled and no transfer in progress, all four drive enables are 0. With the link disabled, including straight after reset, only the card pull-down (`card_pd_o`) is 1.
- R2: Each line input passes through a two-stage synchronizer and then a falling-edge detector. If a low first appears on the master input at rising edge F, the slave pull-down is 0 after edge F+DELAY_CYCLES+1 and 1 after edge F+DELAY_CYCLES+2.
- R3: Only one side can be the slave at a time. While a transfer is in progress, lows on the slave input start nothing and never drive the master side. When both sides fall in the same cycle, the host side becomes master.
- R4: If the master input is seen high at edge R, the slave pull-down stays on after edge R+1. After edge R+2 it is off, and the slave pull-up is on for exactly DELAY_CYCLES cycles.
- R5: If the master input rises again before the copy delay has run out, the slave pull-down is never turned on and the block goes back to idle.
- R6: After the pull-up pulse, the lock is held until both synchronized inputs read high. A low held on the former slave side during this time starts no transfer. Once both sides are high, a new transfer from either side works normally.
- R7: When the enable is low, any transfer is abandoned. The card pull-down is on and the other three enables are off. Lows on the host side start nothing, and re-enabling with both lines released leaves the block idle.
- R8: A transfer led by the card side behaves like one led by the host side, with the roles swapped: the host pull-down follows the R2 timing and the host pull-up follows the R4 timing.
- R9: The pull-down and the pull-up of one side are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| link_en | input | 1 | Card interface active; low forces the card line to ground |
| host_line_i | input | 1 | Level read on the host-side line |
| card_line_i | input | 1 | Level read on the card-side line |
| host_pd_o | output | 1 | Host-side pull-down enable |
| host_pu_o | output | 1 | Host-side active pull-up pulse enable |
| card_pd_o | output | 1 | Card-side pull-down enable |
| card_pu_o | output | 1 | Card-side active pull-up pulse enable |

## Verification
A falling input reaches the edge detector two edges after it is first sampled. The slave pull-down therefore follows DELAY_CYCLES+2 edges after the first sampling edge, and a release reaches the slave drivers two edges after it is sampled. The pull-up then lasts exactly DELAY_CYCLES cycles. The bench changes its inputs just after a rising edge and reads the outputs on the falling edge. Its directed checks step to the exact edge on either side of each transition: the last edge before an output changes and the edge at which it changes. Alongside these, a behavioural model in the bench applies the same latencies and is compared with all four drive enables on every clock. This also covers the abort, the same-cycle tie and the disable cases.

// File: rtl/odl_pkg.sv
package odl_pkg;

    // Index of each side in the per-side arrays
    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } side_e;

    // Transfer phases
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WAIT   = 3'd1,
        PH_HOLD   = 3'd2,
        PH_BOOST  = 3'd3,
        PH_SETTLE = 3'd4
    } phase_e;

    // Drive enables for one side
    typedef struct packed {
        logic pd;
        logic pu;
    } drive_t;

    // Clock cycles covering a time span, rounded up, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                                 input int unsigned span_ns);
        int unsigned c;
        c = (clk_mhz * span_ns + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic side_e opposite(input side_e s);
        return (s == SIDE_HOST) ? SIDE_CARD : SIDE_HOST;
    endfunction

endpackage

// File: rtl/odl_sync.sv
module odl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Stages reset to the released (high) level
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b1;
                else     chain_q[0] <= line_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b1;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign lvl_o = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl_o;
    end

    assign fall_o = prev_q & ~lvl_o;

endmodule

// File: rtl/odl_delay_timer.sv
module odl_delay_timer #(
    parameter int unsigned CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                         cnt_q <= '0;
        else if (load_i)                 cnt_q <= CW'(CYCLES);
        else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // High in the last cycle of a window that was loaded and then ticked
    assign expired_o = (cnt_q == CW'(1));

endmodule

// File: rtl/odl_ctrl.sv
module odl_ctrl
    import odl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_en_i,
    input  logic [1:0]       lvl_i,
    input  logic [1:0]       fall_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic             tick_o,
    output drive_t [1:0]     drv_o
);

    phase_e state_q, state_d;
    side_e  master_q, master_d;
    side_e  slave_side;
    logic   master_high;

    assign slave_side  = opposite(master_q);
    assign master_high = lvl_i[master_q];

    always_comb begin
        state_d  = state_q;
        master_d = master_q;
        load_o   = 1'b0;
        if (!link_en_i) begin
            state_d = PH_IDLE;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (fall_i[SIDE_HOST]) begin
                        state_d  = PH_WAIT;
                        master_d = SIDE_HOST;
                        load_o   = 1'b1;
                    end else if (fall_i[SIDE_CARD]) begin
                        state_d  = PH_WAIT;
                        master_d = SIDE_CARD;
                        load_o   = 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (master_high)     state_d = PH_IDLE;
                    else if (expired_i)  state_d = PH_HOLD;
                end
                PH_HOLD: begin
                    if (master_high) begin
                        state_d = PH_BOOST;
                        load_o  = 1'b1;
                    end
                end
                PH_BOOST: begin
                    if (expired_i) state_d = PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (lvl_i[SIDE_HOST] && lvl_i[SIDE_CARD]) state_d = PH_IDLE;
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    assign tick_o = (state_q == PH_WAIT) || (state_q == PH_BOOST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            master_q <= SIDE_HOST;
        end else begin
            state_q  <= state_d;
            master_q <= master_d;
        end
    end

    always_comb begin
        drv_o = '0;
        if (link_en_i) begin
            drv_o[slave_side].pd = (state_q == PH_HOLD);
            drv_o[slave_side].pu = (state_q == PH_BOOST);
        end else begin
            drv_o[SIDE_CARD].pd = 1'b1;
        end
    end

    logic host_pd_w, host_pu_w, card_pd_w, card_pu_w;
    assign host_pd_w = drv_o[SIDE_HOST].pd;
    assign host_pu_w = drv_o[SIDE_HOST].pu;
    assign card_pd_w = drv_o[SIDE_CARD].pd;
    assign card_pu_w = drv_o[SIDE_CARD].pu;

    // R9
    no_drive_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_pd_w && host_pu_w) && !(card_pd_w && card_pu_w));

    // R7
    disable_forces_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !link_en_i |=> (state_q == PH_IDLE));

    // R5
    card_pd_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (link_en_i && $rose(card_pd_w)) |-> ($past(state_q) == PH_WAIT));

    // R5
    host_pd_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (link_en_i && $rose(host_pd_w)) |-> ($past(state_q) == PH_WAIT));

    // R4
    card_boost_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        (link_en_i && $past(link_en_i) && $fell(card_pd_w)) |-> card_pu_w);

    // R8
    host_boost_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        (link_en_i && $past(link_en_i) && $fell(host_pd_w)) |-> host_pu_w);

endmodule

// File: rtl/odl_repeater.sv
module odl_repeater
    import odl_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 200,
    parameter int unsigned DELAY_NS     = 200,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned DELAY_CYCLES = ns_to_cycles(CLK_MHZ, DELAY_NS)
) (
    input  logic clk,
    input  logic rst,
    input  logic link_en,
    input  logic host_line_i,
    input  logic card_line_i,
    output logic host_pd_o,
    output logic host_pu_o,
    output logic card_pd_o,
    output logic card_pu_o
);

    localparam int unsigned NSIDES = 2;

    logic [NSIDES-1:0] raw;
    logic [NSIDES-1:0] lvl;
    logic [NSIDES-1:0] fall;
    drive_t [NSIDES-1:0] drv;
    logic load, tick, expired;

    assign raw[SIDE_HOST] = host_line_i;
    assign raw[SIDE_CARD] = card_line_i;

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        odl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[s]),
            .lvl_o  (lvl[s]),
            .fall_o (fall[s])
        );
    end

    odl_delay_timer #(.CYCLES(DELAY_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .tick_i    (tick),
        .expired_o (expired)
    );

    odl_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .link_en_i (link_en),
        .lvl_i     (lvl),
        .fall_i    (fall),
        .expired_i (expired),
        .load_o    (load),
        .tick_o    (tick),
        .drv_o     (drv)
    );

    assign host_pd_o = drv[SIDE_HOST].pd;
    assign host_pu_o = drv[SIDE_HOST].pu;
    assign card_pd_o = drv[SIDE_CARD].pd;
    assign card_pu_o = drv[SIDE_CARD].pu;

    // R3
    one_slave_side_chk: assert property (@(posedge clk) disable iff (rst)
        link_en |-> !((host_pd_o || host_pu_o) && (card_pd_o || card_pu_o)));

endmodule

// File: tb/odl_repeater_tb_top.sv
`timescale 1ns/1ps
module odl_repeater_tb_top;

    localparam int D = 40;   // 200 ns at 200 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic host_ext = 1'b0;   // 1: the host device pulls its line low
    logic card_ext = 1'b0;   // 1: the card pulls its line low
    logic host_line, card_line;
    logic host_pd, host_pu, card_pd, card_pu;

    always #2.5 clk = ~clk;

    assign host_line = !(host_ext || host_pd);
    assign card_line = !(card_ext || card_pd);

    odl_repeater dut_i (
        .clk         (clk),
        .rst         (rst),
        .link_en     (en),
        .host_line_i (host_line),
        .card_line_i (card_line),
        .host_pd_o   (host_pd),
        .host_pu_o   (host_pu),
        .card_pd_o   (card_pd),
        .card_pu_o   (card_pu)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";
    bit    watch_card = 1'b0;
    bit    seen_card  = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 delay, 2 hold low, 3 pull-up pulse, 4 settle
    int m_h[$] = '{1, 1};
    int m_c[$] = '{1, 1};
    int m_hprev = 1, m_cprev = 1;
    int m_ph = 0, m_mst = 0, m_tmr = 0;

    task automatic model_step(input int hin, input int cin, input int e, input int r);
        int hl, cl, ml, hf, cf;
        if (r != 0) begin
            m_h = '{1, 1}; m_c = '{1, 1};
            m_hprev = 1; m_cprev = 1; m_ph = 0; m_mst = 0; m_tmr = 0;
            return;
        end
        hl = m_h[1]; cl = m_c[1];
        hf = (m_hprev == 1 && hl == 0) ? 1 : 0;
        cf = (m_cprev == 1 && cl == 0) ? 1 : 0;
        ml = (m_mst == 0) ? hl : cl;
        if (e == 0) m_ph = 0;
        else begin
            case (m_ph)
                0: if (hf == 1) begin m_ph = 1; m_mst = 0; m_tmr = D; end
                   else if (cf == 1) begin m_ph = 1; m_mst = 1; m_tmr = D; end
                1: if (ml == 1) m_ph = 0;
                   else if (m_tmr == 1) m_ph = 2;
                   else m_tmr--;
                2: if (ml == 1) begin m_ph = 3; m_tmr = D; end
                3: if (m_tmr == 1) m_ph = 4; else m_tmr--;
                4: if (hl == 1 && cl == 1) m_ph = 0;
                default: m_ph = 0;
            endcase
        end
        m_hprev = hl; m_cprev = cl;
        void'(m_h.pop_back()); m_h.push_front(hin);
        void'(m_c.pop_back()); m_c.push_front(cin);
    endtask

    always @(negedge clk) begin
        int e_hpd, e_hpu, e_cpd, e_cpu;
        if (!finished) begin
            e_hpd = (en && m_ph == 2 && m_mst == 1) ? 1 : 0;
            e_hpu = (en && m_ph == 3 && m_mst == 1) ? 1 : 0;
            e_cpd = (!en || (m_ph == 2 && m_mst == 0)) ? 1 : 0;
            e_cpu = (en && m_ph == 3 && m_mst == 0) ? 1 : 0;
            chk(cur_req, "model host_pd", int'(host_pd), e_hpd);
            chk(cur_req, "model host_pu", int'(host_pu), e_hpu);
            chk(cur_req, "model card_pd", int'(card_pd), e_cpd);
            chk(cur_req, "model card_pu", int'(card_pu), e_cpu);
            chk("R9", "host pd and pu together", int'(host_pd && host_pu), 0);
            chk("R9", "card pd and pu together", int'(card_pd && card_pu), 0);
            if (watch_card && card_pd) seen_card = 1'b1;
            model_step(int'(host_line), int'(card_line), int'(en), int'(rst));
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    task automatic edge_after();   // next rising edge, then step off it
        @(posedge clk); #1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=done");
            finish_run();
        end
    end

    initial begin
        // R1 reset state, link disabled
        cur_req = "R1";
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset card_pd", int'(card_pd), 1);
        chk("R1", "reset host_pd", int'(host_pd), 0);
        chk("R1", "reset pull-ups", int'(host_pu || card_pu), 0);
        edge_after(); rst = 1'b0;
        cycles(3);
        @(negedge clk);
        chk("R7", "disabled card_pd", int'(card_pd), 1);
        edge_after(); en = 1'b1;
        cycles(8);
        @(negedge clk);
        chk("R1", "enabled idle drives", int'(host_pd || host_pu || card_pd || card_pu), 0);

        // R2 host leads: copy delay
        cur_req = "R2";
        edge_after(); host_ext = 1'b1;          // edge F is the next one
        repeat (D + 2) @(posedge clk);          // edge F+D+1
        @(negedge clk);
        chk("R2", "card_pd before delay end", int'(card_pd), 0);
        @(posedge clk); @(negedge clk);         // edge F+D+2
        chk("R2", "card_pd at delay end", int'(card_pd), 1);

        // R3 card lows during the transfer are ignored
        cur_req = "R3";
        edge_after(); card_ext = 1'b1;
        cycles(20);
        @(negedge clk);
        chk("R3", "host_pd with card low while slave", int'(host_pd), 0);
        edge_after(); card_ext = 1'b0;
        cycles(6);

        // R4 release and pull-up pulse
        cur_req = "R4";
        edge_after(); host_ext = 1'b0;          // edge R is the next one
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R4", "card_pd held at R+1", int'(card_pd), 1);
        @(posedge clk); @(negedge clk);
        chk("R4", "card_pd off at R+2", int'(card_pd), 0);
        chk("R4", "card_pu on at R+2", int'(card_pu), 1);
        repeat (D - 1) @(posedge clk); @(negedge clk);
        chk("R4", "card_pu last cycle", int'(card_pu), 1);
        @(posedge clk); @(negedge clk);
        chk("R4", "card_pu ended", int'(card_pu), 0);
        cycles(10);

        // R8 card leads
        cur_req = "R8";
        edge_after(); card_ext = 1'b1;
        repeat (D + 2) @(posedge clk); @(negedge clk);
        chk("R8", "host_pd before delay end", int'(host_pd), 0);
        @(posedge clk); @(negedge clk);
        chk("R8", "host_pd at delay end", int'(host_pd), 1);
        cycles(10);
        edge_after(); card_ext = 1'b0;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R8", "host_pu on after release", int'(host_pu), 1);
        chk("R8", "host_pd off after release", int'(host_pd), 0);
        repeat (D - 1) @(posedge clk); @(negedge clk);
        chk("R8", "host_pu last cycle", int'(host_pu), 1);
        @(posedge clk); @(negedge clk);
        chk("R8", "host_pu ended", int'(host_pu), 0);
        cycles(10);

        // R5 short low: aborted before the copy
        cur_req = "R5";
        watch_card = 1'b1; seen_card = 1'b0;
        edge_after(); host_ext = 1'b1;
        cycles(10);
        host_ext = 1'b0;
        cycles(D + 20);
        watch_card = 1'b0;
        chk("R5", "card_pd seen during aborted pulse", int'(seen_card), 0);

        // R3 tie, then R6 lock held while card stays low
        cur_req = "R3";
        edge_after(); host_ext = 1'b1; card_ext = 1'b1;
        cycles(D + 6);
        @(negedge clk);
        chk("R3", "tie: card_pd (host is master)", int'(card_pd), 1);
        chk("R3", "tie: host_pd", int'(host_pd), 0);
        cur_req = "R6";
        edge_after(); host_ext = 1'b0;
        cycles(D + 10);
        @(negedge clk);
        chk("R6", "drives after pulse, card still low", int'(host_pd || host_pu || card_pd || card_pu), 0);
        cycles(50);
        @(negedge clk);
        chk("R6", "no card-led transfer while locked", int'(host_pd), 0);
        edge_after(); card_ext = 1'b0;
        cycles(10);
        edge_after(); card_ext = 1'b1;
        repeat (D + 3) @(posedge clk); @(negedge clk);
        chk("R6", "new card transfer after unlock", int'(host_pd), 1);
        edge_after(); card_ext = 1'b0;
        cycles(D + 15);

        // R7 disable in the middle of a transfer
        cur_req = "R7";
        edge_after(); host_ext = 1'b1;
        cycles(D + 6);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7", "disabled card_pd", int'(card_pd), 1);
        chk("R7", "disabled other drives", int'(card_pu || host_pd || host_pu), 0);
        edge_after(); host_ext = 1'b0;
        cycles(D + 10);
        @(negedge clk);
        chk("R7", "no pull-up pulse when disabled", int'(card_pu || host_pu), 0);
        edge_after(); host_ext = 1'b1;
        cycles(20);
        host_ext = 1'b0;
        cycles(10);
        en = 1'b1;
        cycles(D + 20);
        @(negedge clk);
        chk("R7", "idle after re-enable", int'(host_pd || host_pu || card_pd || card_pu), 0);

        finish_run();
    end

endmodule